// File: doc/BRIEF.md
# Stack Frame Push/Pop Sequencer

This block is the stack engine of a small 8-bit processor that has a 16-bit program counter and a 64 KB byte-addressed data space. It owns the stack pointer. When the decoder issues a stack command, the block moves the frame between its ports and memory through a single-byte memory port, one byte per clock. It then steps the stack pointer.

Six commands are supported. Three of them save state: a register-pair save, a subroutine call and interrupt entry. The other three restore it: a register-pair restore, a return, and a return from interrupt. The interrupt frame holds three bytes, because the status byte sits above the two program-counter bytes. Every other frame holds two bytes. Values that are popped appear on dedicated outputs when the command completes.

The block also watches every frame byte address. It flags a frame that touches the status-register window or the boot ROM window. Both windows are parameters. After reset the stack pointer is meaningless until software loads it, so the block rejects stack commands until that first load.

Top module: `stack_seq`

## Requirements
- R1: After reset, `busy`, `done`, `sp_valid`, `mem_we` and `mem_re` are all low.
- R2: When `sp_load` is high and `busy` is low, `sp` takes `sp_load_val` at the next edge and `sp_valid` sets. A command presented in the same cycle is dropped. While `busy` is high, `sp_load` is ignored.
- R3: A legal command issued while `sp_valid` is low makes no memory access and leaves `sp` unchanged. It pulses `err_nosp` for exactly one cycle, in the cycle after the command.
- R4: Command code 0 (pair save) writes `rp_in[15:8]` at SP-1 in the first busy cycle and `rp_in[7:0]` at SP-2 in the second busy cycle. It then sets SP to SP-2.
- R5: Command code 2 (call) writes `pc_in[15:8]` at SP-1 and then `pc_in[7:0]` at SP-2. It then sets SP to SP-2.
- R6: Command code 4 (interrupt entry) writes `psw_in` at SP-1, then `pc_in[15:8]` at SP-2, then `pc_in[7:0]` at SP-3. It then sets SP to SP-3.
- R7: Command code 1 (pair restore) reads the low byte from SP and the high byte from SP+1 into `rp_out`. It then sets SP to SP+2.
- R8: Command code 3 (return) reads `pc_out[7:0]` from SP and `pc_out[15:8]` from SP+1. It then sets SP to SP+2.
- R9: Command code 5 (interrupt return) reads `pc_out[7:0]` from SP, `pc_out[15:8]` from SP+1 and `psw_out` from SP+2. It then sets SP to SP+3.
- R10: An accepted command holds `busy` high for one cycle per frame byte, starting the cycle after acceptance, with exactly one memory access in each of those cycles. The bytes are accessed in the order listed in R4 to R9. `done` pulses for one cycle after the last access. Commands arriving while `busy` is high are ignored, and so are codes 6 and 7.
- R11: Every frame address and every SP update wraps modulo 2^16.
- R12: `err_region` pulses together with `done` when any frame byte address lay in 0xFF00–0xFFFF or 0x0000–0x7FFF. The memory accesses of that frame still take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sp_load | input | 1 | Write `sp_load_val` into the stack pointer |
| sp_load_val | input | 16 | New stack pointer value |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0..5) |
| pc_in | input | 16 | Program counter to save |
| psw_in | input | 8 | Status byte to save |
| rp_in | input | 16 | Register pair to save |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as the address |
| busy | output | 1 | Frame transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Restored program counter |
| psw_out | output | 8 | Restored status byte |
| rp_out | output | 16 | Restored register pair |
| sp | output | 16 | Current stack pointer |
| sp_valid | output | 1 | Stack pointer has been loaded since reset |
| err_region | output | 1 | Frame touched a forbidden window (with `done`) |
| err_nosp | output | 1 | Command rejected because SP was never loaded |

## Verification
The bench runs a save/restore ladder: pair save, call, interrupt entry, then interrupt return, return and pair restore. Restored values that match what was saved show that the write order and the read order mirror each other exactly. Distinct high and low byte values in each frame expose any byte swap. The three-byte frames tell the status position apart from the program-counter bytes. A frame at SP 0x0001 and a restore across 0xFFFF show whether address wrap is handled. Frames that start just inside and just outside the ROM window show where region flagging switches on. Additional patterns cover commands held high while the block is busy, illegal codes, a stack-pointer load that collides with a command, a load issued during a transfer, and commands issued before any load.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

   typedef enum logic [2:0] {
      OP_PUSH = 3'd0,
      OP_POP  = 3'd1,
      OP_CALL = 3'd2,
      OP_RET  = 3'd3,
      OP_IENT = 3'd4,
      OP_RETI = 3'd5
   } stk_op_e;

   function automatic logic op_legal(input logic [2:0] code);
      return code <= 3'd5;
   endfunction

   // frame-saving commands descend from SP, restoring ones ascend
   function automatic logic op_is_write(input stk_op_e op);
      return (op == OP_PUSH) || (op == OP_CALL) || (op == OP_IENT);
   endfunction

   function automatic logic [1:0] op_len(input stk_op_e op);
      return ((op == OP_IENT) || (op == OP_RETI)) ? 2'd3 : 2'd2;
   endfunction

endpackage

// File: rtl/stk_frame_addr.sv
module stk_frame_addr #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] sp_cur,
   input  logic          is_wr,
   input  logic [1:0]    idx,
   output logic [AW-1:0] addr
);
   // saves walk downward from SP-1, restores walk upward from SP
   always_comb begin
      if (is_wr) addr = sp_cur - AW'(idx) - AW'(1);
      else       addr = sp_cur + AW'(idx);
   end
endmodule

// File: rtl/stk_region_chk.sv
module stk_region_chk #(
   parameter int          AW      = 16,
   parameter bit          CHK_SFR = 1'b1,
   parameter int unsigned SFR_LO  = 32'hFF00,
   parameter int unsigned SFR_HI  = 32'hFFFF,
   parameter bit          CHK_ROM = 1'b1,
   parameter int unsigned ROM_LO  = 32'h0000,
   parameter int unsigned ROM_HI  = 32'h7FFF
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   logic sfr_hit, rom_hit;

   // offset-from-base compare avoids a constant lower-bound test
   generate
      if (CHK_SFR) begin : g_sfr
         assign sfr_hit = (addr - AW'(SFR_LO)) <= AW'(SFR_HI - SFR_LO);
      end else begin : g_nosfr
         assign sfr_hit = 1'b0;
      end
      if (CHK_ROM) begin : g_rom
         assign rom_hit = (addr - AW'(ROM_LO)) <= AW'(ROM_HI - ROM_LO);
      end else begin : g_norom
         assign rom_hit = 1'b0;
      end
   endgenerate

   assign hit = sfr_hit | rom_hit;
endmodule

// File: rtl/stk_byte_mux.sv
module stk_byte_mux
   import stack_seq_pkg::*;
#(
   parameter int DW = 8
) (
   input  stk_op_e         op,
   input  logic [1:0]      idx,
   input  logic [2*DW-1:0] pc,
   input  logic [DW-1:0]   psw,
   input  logic [2*DW-1:0] rp,
   output logic [DW-1:0]   wbyte
);
   always_comb begin
      unique case (op)
         OP_PUSH: wbyte = (idx == 2'd0) ? rp[2*DW-1:DW] : rp[DW-1:0];
         OP_CALL: wbyte = (idx == 2'd0) ? pc[2*DW-1:DW] : pc[DW-1:0];
         OP_IENT: begin
            if      (idx == 2'd0) wbyte = psw;
            else if (idx == 2'd1) wbyte = pc[2*DW-1:DW];
            else                  wbyte = pc[DW-1:0];
         end
         default: wbyte = '0;
      endcase
   end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
   import stack_seq_pkg::*;
#(
   parameter int          AW      = 16,
   parameter int          DW      = 8,
   parameter bit          CHK_SFR = 1'b1,
   parameter int unsigned SFR_LO  = 32'hFF00,
   parameter int unsigned SFR_HI  = 32'hFFFF,
   parameter bit          CHK_ROM = 1'b1,
   parameter int unsigned ROM_LO  = 32'h0000,
   parameter int unsigned ROM_HI  = 32'h7FFF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sp_load,
   input  logic [AW-1:0]   sp_load_val,
   input  logic            cmd_valid,
   input  logic [2:0]      cmd_op,
   input  logic [2*DW-1:0] pc_in,
   input  logic [DW-1:0]   psw_in,
   input  logic [2*DW-1:0] rp_in,
   output logic [AW-1:0]   mem_addr,
   output logic            mem_we,
   output logic            mem_re,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata,
   output logic            busy,
   output logic            done,
   output logic [2*DW-1:0] pc_out,
   output logic [DW-1:0]   psw_out,
   output logic [2*DW-1:0] rp_out,
   output logic [AW-1:0]   sp,
   output logic            sp_valid,
   output logic            err_region,
   output logic            err_nosp
);
   localparam int WW = 2 * DW;

   generate
      if (AW < 2) begin : g_bad_aw
         $error("stack_seq: AW must be at least 2");
      end
      if (SFR_LO > SFR_HI) begin : g_bad_sfr
         $error("stack_seq: SFR window bounds reversed");
      end
      if (ROM_LO > ROM_HI) begin : g_bad_rom
         $error("stack_seq: ROM window bounds reversed");
      end
   endgenerate

   logic            busy_q, done_q, ok_q, erracc_q, errreg_q, nosp_q;
   logic [1:0]      idx_q, len_q;
   stk_op_e         op_q;
   logic [AW-1:0]   sp_q;
   logic [WW-1:0]   pc_sv, rp_sv, pc_q, rp_q;
   logic [DW-1:0]   psw_sv, psw_q;
   logic            wr, accept, start, hit;
   logic [AW-1:0]   faddr;
   logic [DW-1:0]   wbyte;

   assign wr     = op_is_write(op_q);
   assign accept = cmd_valid && !busy_q && !sp_load && op_legal(cmd_op);
   assign start  = accept && ok_q;

   stk_frame_addr #(.AW(AW)) u_addr (
      .sp_cur(sp_q), .is_wr(wr), .idx(idx_q), .addr(faddr)
   );

   stk_region_chk #(
      .AW(AW), .CHK_SFR(CHK_SFR), .SFR_LO(SFR_LO), .SFR_HI(SFR_HI),
      .CHK_ROM(CHK_ROM), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)
   ) u_region (
      .addr(faddr), .hit(hit)
   );

   stk_byte_mux #(.DW(DW)) u_mux (
      .op(op_q), .idx(idx_q), .pc(pc_sv), .psw(psw_sv), .rp(rp_sv), .wbyte(wbyte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         ok_q     <= 1'b0;
         erracc_q <= 1'b0;
         errreg_q <= 1'b0;
         nosp_q   <= 1'b0;
         idx_q    <= '0;
         len_q    <= '0;
         op_q     <= OP_PUSH;
         sp_q     <= '0;
         pc_sv    <= '0;
         rp_sv    <= '0;
         psw_sv   <= '0;
         pc_q     <= '0;
         rp_q     <= '0;
         psw_q    <= '0;
      end else begin
         done_q   <= 1'b0;
         errreg_q <= 1'b0;
         nosp_q   <= accept && !ok_q;
         if (sp_load && !busy_q) begin
            sp_q <= sp_load_val;
            ok_q <= 1'b1;
         end
         if (start) begin
            busy_q   <= 1'b1;
            idx_q    <= '0;
            op_q     <= stk_op_e'(cmd_op);
            len_q    <= op_len(stk_op_e'(cmd_op));
            erracc_q <= 1'b0;
            pc_sv    <= pc_in;
            rp_sv    <= rp_in;
            psw_sv   <= psw_in;
         end else if (busy_q) begin
            erracc_q <= erracc_q | hit;
            if (!wr) begin
               unique case (op_q)
                  OP_POP: begin
                     if (idx_q == 2'd0) rp_q[DW-1:0]  <= mem_rdata;
                     else               rp_q[WW-1:DW] <= mem_rdata;
                  end
                  OP_RET, OP_RETI: begin
                     if      (idx_q == 2'd0) pc_q[DW-1:0]  <= mem_rdata;
                     else if (idx_q == 2'd1) pc_q[WW-1:DW] <= mem_rdata;
                     else                    psw_q         <= mem_rdata;
                  end
                  default: ;
               endcase
            end
            if (idx_q == len_q - 2'd1) begin
               busy_q   <= 1'b0;
               done_q   <= 1'b1;
               errreg_q <= erracc_q | hit;
               sp_q     <= wr ? sp_q - AW'(len_q) : sp_q + AW'(len_q);
            end else begin
               idx_q <= idx_q + 2'd1;
            end
         end
      end
   end

   assign mem_addr   = busy_q ? faddr : '0;
   assign mem_we     = busy_q && wr;
   assign mem_re     = busy_q && !wr;
   assign mem_wdata  = (busy_q && wr) ? wbyte : '0;
   assign busy       = busy_q;
   assign done       = done_q;
   assign pc_out     = pc_q;
   assign psw_out    = psw_q;
   assign rp_out     = rp_q;
   assign sp         = sp_q;
   assign sp_valid   = ok_q;
   assign err_region = errreg_q;
   assign err_nosp   = nosp_q;
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sp_load,
   input logic [AW-1:0] sp_load_val,
   input logic          cmd_valid,
   input logic [2:0]    cmd_op,
   input logic          mem_we,
   input logic          mem_re,
   input logic          busy,
   input logic          done,
   input logic [AW-1:0] sp,
   input logic          sp_valid,
   input logic          err_nosp
);
   logic [AW-1:0] sp0;
   logic [1:0]    len0, bcnt;
   logic          wr0, legal, go;

   assign legal = cmd_op <= 3'd5;
   assign go    = cmd_valid && !busy && !sp_load && sp_valid && legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp0  <= '0;
         len0 <= '0;
         wr0  <= 1'b0;
         bcnt <= '0;
      end else begin
         if (go) begin
            sp0  <= sp;
            len0 <= (cmd_op == 3'd4 || cmd_op == 3'd5) ? 2'd3 : 2'd2;
            wr0  <= !cmd_op[0];
         end
         bcnt <= busy ? bcnt + 2'd1 : 2'd0;
      end
   end

   // SP step at completion covers R4 R5 R6 R7 R8 R9 and wraps per R11
   assert_sp_adjust_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> sp == (wr0 ? sp0 - AW'(len0) : sp0 + AW'(len0)));

   assert_busy_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> bcnt < 2'd3);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_access_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> (busy && !(mem_we && mem_re)));

   assert_sp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sp));

   assert_sp_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_load && !busy) |=> (sp == $past(sp_load_val)) && sp_valid);

   assert_no_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && !sp_load && !sp_valid && legal) |=> (err_nosp && !busy));
endmodule

bind stack_seq stack_seq_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sp_load(sp_load), .sp_load_val(sp_load_val),
   .cmd_valid(cmd_valid), .cmd_op(cmd_op), .mem_we(mem_we), .mem_re(mem_re),
   .busy(busy), .done(done), .sp(sp), .sp_valid(sp_valid), .err_nosp(err_nosp)
);

// File: tb/sim_stack_seq.sv
`timescale 1ns/1ps
module sim_stack_seq;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        sp_load = 1'b0, cmd_valid = 1'b0;
   logic [15:0] sp_load_val = '0, pc_in = '0, rp_in = '0;
   logic [2:0]  cmd_op = '0;
   logic [7:0]  psw_in = '0, mem_rdata = '0, mem_wdata;
   logic [15:0] mem_addr, pc_out, rp_out, sp;
   logic [7:0]  psw_out;
   logic        mem_we, mem_re, busy, done, sp_valid, err_region, err_nosp;

   int n_checks = 0, n_errs = 0;

   typedef struct { bit we; logic [15:0] a; logic [7:0] d; int rq; } acc_t;
   acc_t expq[$];
   logic [7:0] mem [logic [15:0]];
   logic [15:0] msp;

   always #10 clk = ~clk;

   stack_seq u0 (
      .clk(clk), .rst_n(rst_n), .sp_load(sp_load), .sp_load_val(sp_load_val),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .pc_in(pc_in), .psw_in(psw_in),
      .rp_in(rp_in), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
      .pc_out(pc_out), .psw_out(psw_out), .rp_out(rp_out), .sp(sp),
      .sp_valid(sp_valid), .err_region(err_region), .err_nosp(err_nosp)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] rdm(input logic [15:0] a);
      return mem.exists(a) ? mem[a] : 8'h00;
   endfunction

   // monitor: pops expected accesses, models the byte memory
   always @(negedge clk) begin
      if (mem_we || mem_re) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R10 unexpected access", {15'd0, mem_we, mem_addr}, 32'h0);
         end else begin
            acc_t e;
            e = expq.pop_front();
            chk(e.a == mem_addr && e.we == mem_we && (!e.we || e.d == mem_wdata),
                $sformatf("R%0d access", e.rq), {7'd0, mem_we, mem_wdata, mem_addr},
                {7'd0, e.we, e.d, e.a});
         end
         if (mem_we) mem[mem_addr] = mem_wdata;
         mem_rdata = mem_re ? rdm(mem_addr) : 8'h00;
      end
   end

   function automatic bit forb(input logic [15:0] a);
      return (a >= 16'hFF00) || (a <= 16'h7FFF);
   endfunction

   task automatic load_sp(input logic [15:0] v);
      @(negedge clk);
      sp_load = 1'b1; sp_load_val = v;
      @(negedge clk);
      sp_load = 1'b0;
      msp = v;
      chk(sp == v && sp_valid, "R2 sp load", {15'd0, sp_valid, sp}, {16'd1, v});
   endtask

   // driver: builds the expected frame from the requirements, issues it
   task automatic do_op(input logic [2:0] op, input int rq, input int hold, input bit ld_mid);
      logic [7:0] b [3];
      logic [7:0] rd [3];
      int n; bit wr, err; int cyc; int i;
      logic [15:0] a;
      n = (op == 3'd4 || op == 3'd5) ? 3 : 2;
      wr = !op[0];
      err = 1'b0;
      case (op)
         3'd0: begin b[0] = rp_in[15:8]; b[1] = rp_in[7:0]; end
         3'd2: begin b[0] = pc_in[15:8]; b[1] = pc_in[7:0]; end
         3'd4: begin b[0] = psw_in; b[1] = pc_in[15:8]; b[2] = pc_in[7:0]; end
         default: begin b[0] = 0; b[1] = 0; b[2] = 0; end
      endcase
      for (int k = 0; k < n; k++) begin
         acc_t e;
         a = wr ? msp - 16'(k + 1) : msp + 16'(k);
         rd[k] = rdm(a);
         err |= forb(a);
         e.we = wr; e.a = a; e.d = wr ? b[k] : 8'h00; e.rq = rq;
         expq.push_back(e);
      end
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op;
      @(negedge clk);
      cyc = 0; i = 0;
      while (!done && cyc < 10) begin
         if (i >= hold) cmd_valid = 1'b0;
         if (ld_mid && i == 0) begin sp_load = 1'b1; sp_load_val = 16'h1111; end
         else sp_load = 1'b0;
         if (busy) cyc++;
         i++;
         @(negedge clk);
      end
      cmd_valid = 1'b0; sp_load = 1'b0;
      msp = wr ? msp - 16'(n) : msp + 16'(n);
      chk(done == 1'b1 && cyc == n, $sformatf("R10 busy length for R%0d", rq), cyc, n);
      chk(sp == msp, $sformatf("R%0d sp update", rq), sp, msp);
      chk(err_region == err, "R12 region flag", err_region, err);
      if (op == 3'd1) chk(rp_out == {rd[1], rd[0]}, "R7 pair restore", rp_out, {rd[1], rd[0]});
      if (op == 3'd3 || op == 3'd5)
         chk(pc_out == {rd[1], rd[0]}, $sformatf("R%0d pc restore", rq), pc_out, {rd[1], rd[0]});
      if (op == 3'd5) chk(psw_out == rd[2], "R9 psw restore", psw_out, rd[2]);
      @(negedge clk);
      chk(!done && !err_region, "R10 done single pulse", {done, err_region}, 0);
      chk(expq.size() == 0, "R10 all accesses made", expq.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

   initial begin
      msp = 16'h0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !sp_valid && !mem_we && !mem_re, "R1 reset state",
          {busy, done, sp_valid, mem_we, mem_re}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: command before any SP load
      cmd_valid = 1'b1; cmd_op = 3'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(err_nosp && !busy, "R3 rejected without SP", {err_nosp, busy}, 2'b10);
      @(negedge clk);
      chk(!err_nosp && !busy, "R3 single pulse", {err_nosp, busy}, 0);

      load_sp(16'h9000);
      rp_in = 16'hA55A; pc_in = 16'h1234; psw_in = 8'h3C;
      do_op(3'd0, 4, 0, 0);            // R4 pair save
      do_op(3'd2, 5, 0, 0);            // R5 call
      pc_in = 16'hBEEF;
      do_op(3'd4, 6, 0, 0);            // R6 interrupt entry
      pc_in = 16'h0; psw_in = 8'h0; rp_in = 16'h0;
      do_op(3'd5, 9, 0, 0);            // R9 interrupt return
      chk(pc_out == 16'hBEEF && psw_out == 8'h3C, "R9 frame round trip", {pc_out, psw_out}, {16'hBEEF, 8'h3C});
      do_op(3'd3, 8, 0, 0);            // R8 return
      chk(pc_out == 16'h1234, "R8 call round trip", pc_out, 16'h1234);
      do_op(3'd1, 7, 0, 0);            // R7 pair restore
      chk(rp_out == 16'hA55A, "R7 pair round trip", rp_out, 16'hA55A);

      // R10: illegal code ignored
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd6;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(!busy && sp == msp && !err_nosp, "R10 illegal code ignored", {busy, sp}, {1'b0, msp});
      @(negedge clk);
      chk(!done && !busy, "R10 illegal code no done", {done, busy}, 0);

      // R10: command held while busy is not re-accepted
      rp_in = 16'h5AA5;
      do_op(3'd0, 10, 2, 0);
      // R2: sp_load during a transfer is ignored
      do_op(3'd1, 2, 0, 1);

      // R2: sp_load wins over a same-cycle command
      @(negedge clk);
      sp_load = 1'b1; sp_load_val = 16'hA000; cmd_valid = 1'b1; cmd_op = 3'd0;
      @(negedge clk);
      sp_load = 1'b0; cmd_valid = 1'b0;
      msp = 16'hA000;
      chk(sp == 16'hA000 && !busy, "R2 load beats command", {busy, sp}, {1'b0, 16'hA000});

      // R11 R12: wrap below zero and across the top
      load_sp(16'h0001);
      pc_in = 16'hC0DE; psw_in = 8'h81;
      do_op(3'd4, 11, 0, 0);
      chk(sp == 16'hFFFE, "R11 wrap downward", sp, 16'hFFFE);
      do_op(3'd5, 11, 0, 0);
      chk(pc_out == 16'hC0DE && psw_out == 8'h81 && sp == 16'h0001, "R11 wrap upward",
          {pc_out, psw_out}, {16'hC0DE, 8'h81});

      // R12: frame straddling the ROM edge, then one just clear of it
      load_sp(16'h8001);
      rp_in = 16'h7E81;
      do_op(3'd0, 12, 0, 0);
      load_sp(16'h8002);
      do_op(3'd0, 12, 0, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end
endmodule